// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

This block is a 32-pin general-purpose I/O port with a small memory-mapped register file. Software drives pins through an output data register and a per-pin output-enable register. It reads the pins back through a synchronised pad-level register. Each pin also has a trigger detector. The detector can flag a low level, a high level, a rising edge, a falling edge, or either edge.

Detected events collect in a sticky status register, and software clears them by writing ones. A mask register selects which pending events reach the two interrupt lines. One line serves pins 0 to 15 and the other serves pins 16 to 31, so each half can be routed to its own interrupt controller input. Pin inputs pass through a two-flop synchroniser before any detection, so asynchronous pads are safe to connect directly.

The register bus is a single-cycle select/write strobe with a combinational read path. Writes take effect on the clock edge at which `bus_sel` and `bus_wr` are both high.

Top module: `gpio_irq_port`

## Requirements
- R1: Out of reset, the data, direction, mask, both-edge and both trigger-configuration registers read 0, `pad_out` and `pad_oe` are 0, and both interrupt outputs are low.
- R2: A write to offset 0x00 drives `pad_out` from the next clock edge, and reading 0x00 returns the last value written, whatever the direction setting.
- R3: A write to offset 0x04 sets `pad_oe`; a 1 bit enables the output driver of that pin and a 0 bit leaves it tristated.
- R4: Reading offset 0x08 returns `pad_in` delayed by two clock edges through the synchroniser. A change is not yet visible after one edge.
- R5: Pin p takes its 2-bit trigger code from bits [2*(p mod 16)+1 : 2*(p mod 16)]. The register is offset 0x0C for pins 0 to 15 and offset 0x10 for pins 16 to 31. The codes are 00 = low level, 01 = high level, 10 = rising edge and 11 = falling edge.
- R6: In an edge mode, the status bit is set once, on the third clock edge after the pad transition of the selected polarity. A transition of the other polarity sets nothing.
- R7: In a level mode, the status bit is set on every cycle the level is present. A clear written while the level persists leaves the bit at 1, and the bit can only be cleared once the level has gone.
- R8: When a pin's bit in the both-edge register (offset 0x1C) is 1, that pin flags both rising and falling transitions, and its 2-bit trigger code has no effect.
- R9: The status register (offset 0x18) is sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. Status bits never fall except on a write to 0x18.
- R10: When a detection and a clear-by-write hit the same status bit in the same cycle, the bit ends up set.
- R11: `irq_lo` is the OR over pins 0 to 15 of status AND mask (offset 0x14), and `irq_hi` is the same OR over pins 16 to 31. A mask bit of 0 keeps that pin from either line.
- R12: A write to the pad-level offset 0x08 changes nothing. Reads of offsets with no register (for example 0x20) return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational on bus_addr) |
| pad_in | input | 32 | Asynchronous pin levels |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin |
| irq_lo | output | 1 | Interrupt for pins 0 to 15 |
| irq_hi | output | 1 | Interrupt for pins 16 to 31 |

## Verification
The bench reads the pad-level register one edge after a pad change and expects to see the old value there. A design missing one synchroniser stage would already show the new level. Each edge polarity is driven in both directions, so a detector that reacts to any change would set status on the wrong transition. A both-edge pin is given a rising-only code to show the override, and a level pin is cleared while its level is held, which exposes a clear that beats the set. Pins on each half of the port check the field placement in the two configuration words and the routing to the correct interrupt line; a swapped half would raise the other output.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam logic [5:0] OFS_DATA   = 6'h00;
    localparam logic [5:0] OFS_DIR    = 6'h04;
    localparam logic [5:0] OFS_LEVEL  = 6'h08;
    localparam logic [5:0] OFS_CFG_LO = 6'h0C;
    localparam logic [5:0] OFS_CFG_HI = 6'h10;
    localparam logic [5:0] OFS_MASK   = 6'h14;
    localparam logic [5:0] OFS_STATUS = 6'h18;
    localparam logic [5:0] OFS_BOTH   = 6'h1C;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);
    logic [W-1:0] meta_q;

    // two flops for metastability, a third holds the prior sample for edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            lvl      <= '0;
            lvl_prev <= '0;
        end else begin
            meta_q   <= raw;
            lvl      <= meta_q;
            lvl_prev <= lvl;
        end
    end
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_port_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]   lvl,
    input  logic [W-1:0]   lvl_prev,
    input  logic [2*W-1:0] cfg,
    input  logic [W-1:0]   both,
    output logic [W-1:0]   hit
);
    for (genvar p = 0; p < W; p++) begin : g_pin
        trig_e mode;
        assign mode = trig_e'(cfg[2*p +: 2]);

        always_comb begin
            if (both[p]) begin
                hit[p] = lvl[p] ^ lvl_prev[p];
            end else begin
                unique case (mode)
                    TRIG_LOW:  hit[p] = ~lvl[p];
                    TRIG_HIGH: hit[p] = lvl[p];
                    TRIG_RISE: hit[p] = lvl[p] & ~lvl_prev[p];
                    TRIG_FALL: hit[p] = ~lvl[p] & lvl_prev[p];
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [DATA_W-1:0]   lvl,
    input  logic [DATA_W-1:0]   hit,
    output logic [DATA_W-1:0]   data_q,
    output logic [DATA_W-1:0]   dir_q,
    output logic [2*DATA_W-1:0] cfg,
    output logic [DATA_W-1:0]   both_q,
    output logic [DATA_W-1:0]   msk_q,
    output logic [DATA_W-1:0]   st_q
);
    logic              wr_en;
    logic [DATA_W-1:0] cfg_lo_q, cfg_hi_q, clr;

    assign wr_en = bus_sel & bus_wr;
    assign cfg   = {cfg_hi_q, cfg_lo_q};
    assign clr   = (wr_en && bus_addr == ADDR_W'(OFS_STATUS)) ? bus_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            dir_q    <= '0;
            cfg_lo_q <= '0;
            cfg_hi_q <= '0;
            msk_q    <= '0;
            both_q   <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                ADDR_W'(OFS_DATA):   data_q   <= bus_wdata;
                ADDR_W'(OFS_DIR):    dir_q    <= bus_wdata;
                ADDR_W'(OFS_CFG_LO): cfg_lo_q <= bus_wdata;
                ADDR_W'(OFS_CFG_HI): cfg_hi_q <= bus_wdata;
                ADDR_W'(OFS_MASK):   msk_q    <= bus_wdata;
                ADDR_W'(OFS_BOTH):   both_q   <= bus_wdata;
                default: ;
            endcase
        end
    end

    // sticky status: a detection in the same cycle overrides the clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~clr) | hit;
    end

    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_DATA):   bus_rdata = data_q;
            ADDR_W'(OFS_DIR):    bus_rdata = dir_q;
            ADDR_W'(OFS_LEVEL):  bus_rdata = lvl;
            ADDR_W'(OFS_CFG_LO): bus_rdata = cfg_lo_q;
            ADDR_W'(OFS_CFG_HI): bus_rdata = cfg_hi_q;
            ADDR_W'(OFS_MASK):   bus_rdata = msk_q;
            ADDR_W'(OFS_STATUS): bus_rdata = st_q;
            ADDR_W'(OFS_BOTH):   bus_rdata = both_q;
            default:             bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pad_in,
    output logic [DATA_W-1:0] pad_out,
    output logic [DATA_W-1:0] pad_oe,
    output logic              irq_lo,
    output logic              irq_hi
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0]   lvl, lvl_prev, hit, both_q, msk_q, st_q, pend;
    logic [2*DATA_W-1:0] cfg;

    gpio_sync #(.W(DATA_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (pad_in),
        .lvl      (lvl),
        .lvl_prev (lvl_prev)
    );

    gpio_trig_detect #(.W(DATA_W)) u_det (
        .lvl      (lvl),
        .lvl_prev (lvl_prev),
        .cfg      (cfg),
        .both     (both_q),
        .hit      (hit)
    );

    gpio_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lvl       (lvl),
        .hit       (hit),
        .data_q    (pad_out),
        .dir_q     (pad_oe),
        .cfg       (cfg),
        .both_q    (both_q),
        .msk_q     (msk_q),
        .st_q      (st_q)
    );

    assign pend   = st_q & msk_q;
    assign irq_lo = |pend[HALF-1:0];
    assign irq_hi = |pend[DATA_W-1:HALF];
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_port_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] pad_out,
    input logic [DATA_W-1:0] pad_oe,
    input logic [DATA_W-1:0] st_q,
    input logic [DATA_W-1:0] msk_q,
    input logic              irq_lo,
    input logic              irq_hi
);
    localparam int HALF = DATA_W / 2;

    a_r2_data_drives_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_DATA)) |=> pad_out == $past(bus_wdata));

    a_r3_dir_drives_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_DIR)) |=> pad_oe == $past(bus_wdata));

    a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_STATUS)) |=> ((st_q & $past(st_q)) == $past(st_q)));

    a_r11_lo_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_q[HALF-1:0] == '0) |-> !irq_lo);

    a_r11_hi_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_q[DATA_W-1:HALF] == '0) |-> !irq_hi);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .st_q      (st_q),
    .msk_q     (msk_q),
    .irq_lo    (irq_lo),
    .irq_hi    (irq_hi)
);

// File: tb/tb_gpio_irq_port.sv
`timescale 1ns/1ps
module tb_gpio_irq_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq_lo, irq_hi;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [31:0] ALL_RISE = 32'hAAAA_AAAA;

    always #4 clk = ~clk;   // 125 MHz

    gpio_irq_port dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 irq", {30'h0, irq_hi, irq_lo}, 32'h0);
        rd(6'h00, v); check("R1 data", v, 32'h0);
        rd(6'h04, v); check("R1 dir", v, 32'h0);
        rd(6'h0C, v); check("R1 cfg lo", v, 32'h0);
        rd(6'h10, v); check("R1 cfg hi", v, 32'h0);
        rd(6'h14, v); check("R1 mask", v, 32'h0);
        rd(6'h1C, v); check("R1 both", v, 32'h0);
    endtask

    task automatic t_setup();
        logic [31:0] v;
        wr(6'h0C, ALL_RISE);
        wr(6'h10, ALL_RISE);
        tick(4);
        wr(6'h18, 32'hFFFF_FFFF);
        rd(6'h18, v); check("R9 clear all", v, 32'h0);
    endtask

    task automatic t_data_dir();
        logic [31:0] v;
        wr(6'h00, 32'h1234_5678);
        check("R2 pad_out", pad_out, 32'h1234_5678);
        check("R3 oe still off", pad_oe, 32'h0);
        rd(6'h00, v); check("R2 readback", v, 32'h1234_5678);
        wr(6'h04, 32'h0000_FFFF);
        check("R3 pad_oe", pad_oe, 32'h0000_FFFF);
        rd(6'h00, v); check("R2 readback with dir", v, 32'h1234_5678);
    endtask

    task automatic t_pad_level();
        logic [31:0] v;
        @(negedge clk);
        pad_in = 32'hA5A5_0000;
        tick(1);
        rd(6'h08, v); check("R4 not yet visible", v, 32'h0);
        tick(2);
        rd(6'h08, v); check("R4 level", v, 32'hA5A5_0000);
        wr(6'h08, 32'h0);
        rd(6'h08, v); check("R12 level write ignored", v, 32'hA5A5_0000);
        rd(6'h20, v); check("R12 unmapped", v, 32'h0);
        pad_in = 32'h0;
        tick(4);
        wr(6'h18, 32'hFFFF_FFFF);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        @(negedge clk);
        pad_in[3] = 1'b1;
        tick(2);
        rd(6'h18, v); check("R6 rise timing early", v, 32'h0);
        tick(1);
        rd(6'h18, v); check("R6 rise sets", v, 32'h0000_0008);
        check("R11 masked off", {30'h0, irq_hi, irq_lo}, 32'h0);
        wr(6'h14, 32'h0000_0008);
        check("R11 irq_lo", {30'h0, irq_hi, irq_lo}, 32'h1);
        wr(6'h18, 32'h0000_0008);
        check("R9 clear drops irq", {30'h0, irq_hi, irq_lo}, 32'h0);
        pad_in[3] = 1'b0;
        tick(4);
        rd(6'h18, v); check("R6 fall ignored in rise mode", v, 32'h0);
        wr(6'h14, 32'h0);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        wr(6'h10, 32'hAAAA_ABAA);   // pin 20 -> code 11 (R5)
        pad_in[20] = 1'b1;
        tick(4);
        rd(6'h18, v); check("R6 rise ignored in fall mode", v, 32'h0);
        pad_in[20] = 1'b0;
        tick(4);
        rd(6'h18, v); check("R5 fall on upper pin", v, 32'h0010_0000);
        wr(6'h14, 32'h0010_0000);
        check("R11 irq_hi", {30'h0, irq_hi, irq_lo}, 32'h2);
        wr(6'h18, 32'hFFFF_FFFF);
        wr(6'h14, 32'h0);
        wr(6'h10, ALL_RISE);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(6'h0C, 32'hAAAA_A6AA);   // pin 5 -> code 01 high level
        pad_in[5] = 1'b1;
        tick(4);
        rd(6'h18, v); check("R7 high level", v, 32'h0000_0020);
        wr(6'h18, 32'h0000_0020);
        rd(6'h18, v); check("R10 set beats clear", v, 32'h0000_0020);
        wr(6'h18, 32'h0);
        rd(6'h18, v); check("R9 zero write keeps", v, 32'h0000_0020);
        pad_in[5] = 1'b0;
        tick(4);
        wr(6'h18, 32'h0000_0020);
        rd(6'h18, v); check("R7 cleared after level gone", v, 32'h0);
        wr(6'h0C, 32'hAAAA_8AAA);   // pin 6 -> code 00 low level
        tick(4);
        wr(6'h18, 32'hFFFF_FFFF);
        rd(6'h18, v); check("R7 low level persists", v, 32'h0000_0040);
        pad_in[6] = 1'b1;
        tick(4);
        wr(6'h18, 32'hFFFF_FFFF);
        wr(6'h0C, ALL_RISE);
        tick(1);
        wr(6'h18, 32'hFFFF_FFFF);
        rd(6'h18, v); check("R7 low level ends", v, 32'h0);
        pad_in[6] = 1'b0;
        tick(4);
    endtask

    task automatic t_both();
        logic [31:0] v;
        wr(6'h1C, 32'h0000_0100);   // pin 8 both edges, code still rising
        pad_in[8] = 1'b1;
        tick(4);
        rd(6'h18, v); check("R8 both rise", v, 32'h0000_0100);
        wr(6'h18, 32'h0000_0100);
        pad_in[8] = 1'b0;
        tick(4);
        rd(6'h18, v); check("R8 both fall overrides code", v, 32'h0000_0100);
        wr(6'h18, 32'hFFFF_FFFF);
        wr(6'h1C, 32'h0);
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_setup();
        t_data_dir();
        t_pad_level();
        t_rise();
        t_fall();
        t_level();
        t_both();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule